// File: doc/BRIEF.md
# Dual-Slope Digital Ramp Generator

This block sweeps a 32-bit unsigned accumulator between a programmable floor and a programmable ceiling. The rising and falling slopes each have their own step word and their own 16-bit interval word. A direction input picks the slope. On a rising step the accumulator adds the rising step word and stops at the ceiling. On a falling step it subtracts the falling step word and stops at the floor.

Each step result is routed to one of three synthesizer control words, and the top bits of the accumulator are aligned to the most significant bit of the chosen word. A 2-bit destination code picks the word: the 32-bit frequency word, the 16-bit phase word or the 14-bit amplitude word. The chosen word gets a one-cycle write strobe with each new value. A limit flag reports when the ramp has reached the limit it is moving toward. A clear input forces the accumulator to the floor. When the enable input is low the block ignores every other control and holds its state.

Top module: `slope_ramp`

## Requirements
- R1: While reset is asserted and after it is released, all three output words read 0 and all three write strobes are low, until the first update.
- R2: While `rampEn` is low, the accumulator, the interval counter, the output words and the direction memory hold their values. No write strobe rises, and `accClear` has no effect.
- R3: When `rampEn` is high and `rampUp` has been steady, a rising step adds `riseStep` once every `riseRate`+1 cycles. The interval counter reloads from `riseRate` after each step.
- R4: A rising step whose sum passes `ceilLim`, or passes 2^32-1, leaves the accumulator at `ceilLim`.
- R5: With `rampUp` low, a falling step subtracts `fallStep` once every `fallRate`+1 cycles. If the result would go below `floorLim`, or below zero, the accumulator is set to `floorLim`.
- R6: In any enabled cycle where `rampUp` differs from its value at the last enabled edge, no step is taken. The interval counter reloads from the rate word of the new direction.
- R7: With `rampEn` high, `accClear` sets the accumulator to `floorLim` at the next edge and reloads the interval counter. This happens even if a step would have fallen due in that cycle. The clear counts as an update.
- R8: After each update with `destSel`=00, `freqWord` holds accumulator bits 31:0 and `freqWr` is high for exactly one cycle. At most one write strobe is high at any time.
- R9: After each update with `destSel`=01, `phaseWord` holds accumulator bits 31:16 and `phaseWr` is high for one cycle.
- R10: After each update with `destSel`=10 or 11, `ampWord` holds accumulator bits 31:18 and `ampWr` is high for one cycle. The words that were not selected keep their values.
- R11: `rampOver` is high exactly when the accumulator equals `ceilLim` while `rampUp` is high, or equals `floorLim` while `rampUp` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rampEn | input | 1 | Enable. When low, every other control is ignored |
| rampUp | input | 1 | 1 = rising slope, 0 = falling slope |
| accClear | input | 1 | Force the accumulator to the floor |
| ceilLim | input | 32 | Upper limit |
| floorLim | input | 32 | Lower limit |
| riseStep | input | 32 | Step added on a rising step |
| fallStep | input | 32 | Step subtracted on a falling step |
| riseRate | input | 16 | Rising interval word; a step every riseRate+1 cycles |
| fallRate | input | 16 | Falling interval word; a step every fallRate+1 cycles |
| destSel | input | 2 | 00 frequency, 01 phase, 1x amplitude |
| freqWord | output | 32 | Frequency control word |
| phaseWord | output | 16 | Phase control word |
| ampWord | output | 14 | Amplitude control word |
| freqWr | output | 1 | One-cycle strobe when freqWord changes |
| phaseWr | output | 1 | One-cycle strobe when phaseWord changes |
| ampWr | output | 1 | One-cycle strobe when ampWord changes |
| rampOver | output | 1 | Accumulator is at the limit it is heading toward |

## Verification
A clear can arrive in the same cycle that the interval counter expires. In that case the clear must win: the floor is loaded and no step result appears. A direction reversal can also land on an expiry cycle, and then it must drop the step and reload from the new slope's rate. Short rate words, frequent direction flips and occasional clears in the random phase make both collisions happen often, and some directed cases force them. A cycle-accurate bench model, built from the requirements, judges the exact words, strobes and limit flag after every edge.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic step;   // take one slope step this edge
    logic up;     // slope of that step
    logic clear;  // load the floor this edge
  } rampCtl_t;
endpackage

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_pkg::*;
#(
  parameter int RateW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rampEn,
  input  logic             rampUp,
  input  logic             accClear,
  input  logic [RateW-1:0] riseRate,
  input  logic [RateW-1:0] fallRate,
  output rampCtl_t         ctl
);
  logic [RateW-1:0] cnt;
  logic             prevDir;
  logic [RateW-1:0] rateSel;
  logic             turn;
  logic             expired;

  assign rateSel = rampUp ? riseRate : fallRate;
  assign turn    = rampUp != prevDir;
  assign expired = cnt == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      prevDir <= 1'b0;
    end else if (rampEn) begin
      prevDir <= rampUp;
      if (accClear || turn || expired) cnt <= rateSel;
      else                             cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    ctl.up    = rampUp;
    ctl.clear = rampEn && accClear;
    ctl.step  = rampEn && !accClear && !turn && expired;
  end

  // R2: nothing is issued while disabled
  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rampEn |-> !ctl.step && !ctl.clear);
  // R6: a reversal reloads the counter from the new slope's rate
  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rampEn && !accClear && turn) |=> cnt == $past(rateSel));
  // R3: back-to-back steps only when the rate word is zero
  p_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (!ctl.step || $past(rateSel) == '0));
endmodule

// File: rtl/ramp_dp.sv
module ramp_dp
  import ramp_pkg::*;
#(
  parameter int AccW   = 32,
  parameter int PhaseW = 16,
  parameter int AmpW   = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampCtl_t          ctl,
  input  logic [AccW-1:0]   ceilLim,
  input  logic [AccW-1:0]   floorLim,
  input  logic [AccW-1:0]   riseStep,
  input  logic [AccW-1:0]   fallStep,
  input  logic [1:0]        destSel,
  output logic [AccW-1:0]   freqWord,
  output logic [PhaseW-1:0] phaseWord,
  output logic [AmpW-1:0]   ampWord,
  output logic              freqWr,
  output logic              phaseWr,
  output logic              ampWr,
  output logic              rampOver
);
  logic [AccW-1:0] acc;
  logic [AccW:0]   sumRise;
  logic [AccW-1:0] diffFall;
  logic [AccW-1:0] riseVal;
  logic [AccW-1:0] fallVal;
  logic [AccW-1:0] accNext;
  logic            load;

  always_comb begin
    sumRise  = {1'b0, acc} + {1'b0, riseStep};
    diffFall = acc - fallStep;
    riseVal  = (sumRise[AccW] || sumRise[AccW-1:0] > ceilLim) ? ceilLim : sumRise[AccW-1:0];
    fallVal  = (acc < fallStep || diffFall < floorLim) ? floorLim : diffFall;
    load     = ctl.clear || ctl.step;
    if (ctl.clear)     accNext = floorLim;
    else if (ctl.step) accNext = ctl.up ? riseVal : fallVal;
    else               accNext = acc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      freqWord  <= '0;
      phaseWord <= '0;
      ampWord   <= '0;
      freqWr    <= 1'b0;
      phaseWr   <= 1'b0;
      ampWr     <= 1'b0;
    end else begin
      acc     <= accNext;
      freqWr  <= 1'b0;
      phaseWr <= 1'b0;
      ampWr   <= 1'b0;
      if (load) begin
        unique casez (destSel)
          2'b00: begin freqWord  <= accNext;                     freqWr  <= 1'b1; end
          2'b01: begin phaseWord <= accNext[AccW-1 -: PhaseW];   phaseWr <= 1'b1; end
          default: begin ampWord <= accNext[AccW-1 -: AmpW];     ampWr   <= 1'b1; end
        endcase
      end
    end
  end

  assign rampOver = ctl.up ? (acc == ceilLim) : (acc == floorLim);

  // R4: a rising step never lands above the ceiling
  p_ceil_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ctl.up) |=> acc <= $past(ceilLim));
  // R5: a falling step never lands below the floor
  p_floor_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.up) |=> acc >= $past(floorLim));
  // R7: clear loads the floor
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> acc == $past(floorLim));
  // R2: frozen when nothing is issued
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.step || ctl.clear) |=> $stable(acc) && !freqWr && !phaseWr && !ampWr);
  // R8: at most one destination strobe
  p_onewr_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({freqWr, phaseWr, ampWr}));
endmodule

// File: rtl/slope_ramp.sv
module slope_ramp
  import ramp_pkg::*;
#(
  parameter int AccW   = 32,
  parameter int RateW  = 16,
  parameter int PhaseW = 16,
  parameter int AmpW   = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rampEn,
  input  logic              rampUp,
  input  logic              accClear,
  input  logic [AccW-1:0]   ceilLim,
  input  logic [AccW-1:0]   floorLim,
  input  logic [AccW-1:0]   riseStep,
  input  logic [AccW-1:0]   fallStep,
  input  logic [RateW-1:0]  riseRate,
  input  logic [RateW-1:0]  fallRate,
  input  logic [1:0]        destSel,
  output logic [AccW-1:0]   freqWord,
  output logic [PhaseW-1:0] phaseWord,
  output logic [AmpW-1:0]   ampWord,
  output logic              freqWr,
  output logic              phaseWr,
  output logic              ampWr,
  output logic              rampOver
);
  rampCtl_t ctl;

  ramp_ctrl #(.RateW(RateW)) u_ctrl (
    .clk(clk), .rstN(rstN), .rampEn(rampEn), .rampUp(rampUp),
    .accClear(accClear), .riseRate(riseRate), .fallRate(fallRate), .ctl(ctl)
  );

  ramp_dp #(.AccW(AccW), .PhaseW(PhaseW), .AmpW(AmpW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .ceilLim(ceilLim), .floorLim(floorLim), .riseStep(riseStep), .fallStep(fallStep),
    .destSel(destSel), .freqWord(freqWord), .phaseWord(phaseWord), .ampWord(ampWord),
    .freqWr(freqWr), .phaseWr(phaseWr), .ampWr(ampWr), .rampOver(rampOver)
  );
endmodule

// File: tb/sim_slope_ramp.sv
`timescale 1ns/1ps
module sim_slope_ramp;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rampEn = 1'b0, rampUp = 1'b0, accClear = 1'b0;
  logic [31:0] ceilLim = '0, floorLim = '0, riseStep = '0, fallStep = '0;
  logic [15:0] riseRate = '0, fallRate = '0;
  logic [1:0]  destSel = '0;
  logic [31:0] freqWord;
  logic [15:0] phaseWord;
  logic [13:0] ampWord;
  logic        freqWr, phaseWr, ampWr, rampOver;

  int errors = 0, checks = 0;

  // bench model
  logic [31:0] mAcc = '0, mFreq = '0;
  logic [15:0] mCnt = '0, mPhase = '0;
  logic [13:0] mAmp = '0;
  logic        mPrev = 1'b0;
  logic [2:0]  mWr = '0;
  string       evTag = "R1";

  always #10 clk = ~clk;

  slope_ramp u0 (
    .clk(clk), .rstN(rstN), .rampEn(rampEn), .rampUp(rampUp), .accClear(accClear),
    .ceilLim(ceilLim), .floorLim(floorLim), .riseStep(riseStep), .fallStep(fallStep),
    .riseRate(riseRate), .fallRate(fallRate), .destSel(destSel),
    .freqWord(freqWord), .phaseWord(phaseWord), .ampWord(ampWord),
    .freqWr(freqWr), .phaseWr(phaseWr), .ampWr(ampWr), .rampOver(rampOver)
  );

  function automatic logic [31:0] riseOf(logic [31:0] a, logic [31:0] s, logic [31:0] c);
    logic [32:0] t = {1'b0, a} + {1'b0, s};
    return (t > {1'b0, c}) ? c : t[31:0];
  endfunction

  function automatic logic [31:0] fallOf(logic [31:0] a, logic [31:0] s, logic [31:0] f);
    if (a < s) return f;
    return (a - s < f) ? f : a - s;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    logic upd = 1'b0;
    logic [15:0] rate = rampUp ? riseRate : fallRate;
    if (!rampEn) evTag = "R2";
    else if (accClear) begin
      mAcc = floorLim; mCnt = rate; mPrev = rampUp; upd = 1'b1; evTag = "R7";
    end else if (rampUp != mPrev) begin
      mCnt = rate; mPrev = rampUp; evTag = "R6";
    end else if (mCnt == 0) begin
      if (rampUp) begin
        evTag = ({1'b0, mAcc} + {1'b0, riseStep} > {1'b0, ceilLim}) ? "R4" : "R3";
        mAcc = riseOf(mAcc, riseStep, ceilLim);
      end else begin
        evTag = "R5";
        mAcc = fallOf(mAcc, fallStep, floorLim);
      end
      mCnt = rate; upd = 1'b1;
    end else begin
      mCnt = mCnt - 1'b1; evTag = rampUp ? "R3" : "R5";
    end
    mWr = '0;
    if (upd) begin
      if (destSel == 2'b00)      begin mFreq = mAcc;         mWr = 3'b001; end
      else if (destSel == 2'b01) begin mPhase = mAcc[31:16]; mWr = 3'b010; end
      else                       begin mAmp = mAcc[31:18];   mWr = 3'b100; end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rstN) modelEdge();
    #1;
    check($sformatf("R8 freqWord (%s)", evTag), freqWord, mFreq);
    check($sformatf("R9 phaseWord (%s)", evTag), {16'h0, phaseWord}, {16'h0, mPhase});
    check($sformatf("R10 ampWord (%s)", evTag), {18'h0, ampWord}, {18'h0, mAmp});
    check($sformatf("R8 strobes (%s)", evTag), {29'h0, ampWr, phaseWr, freqWr}, {29'h0, mWr});
    check($sformatf("R11 rampOver (%s)", evTag), {31'h0, rampOver},
          {31'h0, rampUp ? (mAcc == ceilLim) : (mAcc == floorLim)});
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 freqWord", freqWord, 32'h0);
    check("R1 strobes", {29'h0, ampWr, phaseWr, freqWr}, 32'h0);
    rstN = 1'b1;
    run(2);
    check("R1 phaseWord", {16'h0, phaseWord}, 32'h0);

    // directed rising to ceiling, frequency destination
    floorLim = 32'd100; ceilLim = 32'd1000; riseStep = 32'd300; fallStep = 32'd250;
    riseRate = 16'd2; fallRate = 16'd1; destSel = 2'b00; rampEn = 1'b1;
    accClear = 1'b1; run(1); accClear = 1'b0;
    rampUp = 1'b1; run(16);
    check("R4 saturated at ceiling", freqWord, 32'd1000);
    // reverse: falling to floor, phase destination
    rampUp = 1'b0; destSel = 2'b01; run(14);
    // clear colliding with expiry, then amplitude destination
    fallRate = 16'd0; destSel = 2'b10; accClear = 1'b1; run(1); accClear = 1'b0;
    check("R7 clear over step", {18'h0, ampWord}, {18'h0, floorLim[31:18]});
    // overflow of a rising step
    ceilLim = 32'hFFFF_FFFF; riseStep = 32'hC000_0000; riseRate = 16'd0; rampUp = 1'b1;
    destSel = 2'b11; run(6);
    // underflow of a falling step
    floorLim = 32'd5; fallStep = 32'hF000_0000; rampUp = 1'b0; run(6);
    // disabled: clear and direction ignored
    rampEn = 1'b0; accClear = 1'b1; rampUp = 1'b1; run(5); accClear = 1'b0;
    check("R2 frozen while disabled", {18'h0, ampWord}, {18'h0, mAmp});
    rampEn = 1'b1;

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        floorLim = $urandom_range(0, 32'h000F_FFFF);
        ceilLim  = floorLim + $urandom_range(0, 32'h003F_FFFF);
        riseStep = $urandom_range(0, 32'h0007_FFFF);
        fallStep = $urandom_range(0, 32'h0007_FFFF);
      end
      if ($urandom_range(0, 15) == 0) rampUp = ~rampUp;
      if ($urandom_range(0, 31) == 0) destSel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) rampEn = ~rampEn;
      accClear = ($urandom_range(0, 63) == 0);
      if ($urandom_range(0, 63) == 0) riseRate = 16'($urandom_range(0, 5));
      if ($urandom_range(0, 63) == 0) fallRate = 16'($urandom_range(0, 5));
      cycle();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule